// File: doc/BRIEF.md
# Serially Loaded Mapper Register Block with Three-Wire EEPROM Port

This block holds the four configuration registers of a cartridge memory mapper. The CPU cannot write them in parallel. Each write into the upper half of the address space ($8000-$FFFF) delivers a single bit on data bit 0. After five such writes, the assembled value goes into one register. Address bits 14:13 of the fifth write pick that register. A write with data bit 7 set aborts a partly assembled value.

Some bits of these registers also drive a bit-banged serial EEPROM:

- Chip select comes from a pattern in the control register.
- The data line comes from the first character-bank register, and only when the control register selects small character banks.
- The clock also comes from the first character-bank register.

The EEPROM's serial output comes back to the CPU on data bit 0. This happens on any read in the work-RAM window ($6000-$7FFF) while the program-bank register allows it. The block also produces the cartridge SRAM enable. It exposes the four register values for the address logic that sits around it.

Top module: `sermap_eeprom_top`

## Requirements
- R1: A write in $8000-$FFFF with data bit 7 = 1 discards any partly collected bits. The next write then starts a fresh five-bit value. No register changes on such a write.
- R2: A write in $8000-$FFFF with data bit 7 = 0 collects data bit 0, least significant bit first. The fifth such write stores the five bits in the register chosen by address bits 14:13: 0 = control, 1 = character bank 0, 2 = character bank 1, 3 = program bank.
- R3: Writes below $8000, reads anywhere, and idle bus cycles change neither a register nor the count of collected bits.
- R4: Synchronous reset sets control to 5'h0C and the other three registers to 0, and empties the collector.
- R5: The EEPROM chip select is 1 exactly when control bits 1:0 equal 2'b01.
- R6: The EEPROM data-in equals character bank 0 bit 0 while control bit 4 is 1. It is 0 while control bit 4 is 0.
- R7: The EEPROM clock equals character bank 0 bit 1.
- R8: The SRAM enable is the inverse of character bank 0 bit 4.
- R9: During a read cycle with an address in $6000-$7FFF and program bank bit 4 = 0, output-enable bit 0 is 1 and bus bit 0 carries the EEPROM data-out level.
- R10: No output-enable bit other than bit 0 is ever 1. Output-enable bit 0 is 0 on writes, on idle cycles, outside $6000-$7FFF, and whenever program bank bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cycle | input | 1 | Marks one clock as a valid CPU access |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU data written |
| ee_do | input | 1 | Serial data from the EEPROM |
| ctrl_q | output | 5 | Control register |
| chr0_q | output | 5 | Character bank register 0 |
| chr1_q | output | 5 | Character bank register 1 |
| prg_q | output | 5 | Program bank register |
| ee_cs | output | 1 | EEPROM chip select |
| ee_di | output | 1 | EEPROM serial data in |
| ee_clk | output | 1 | EEPROM serial clock |
| sram_en | output | 1 | Cartridge SRAM enable |
| bus_rdata | output | 8 | Data driven toward the CPU |
| bus_oe | output | 8 | Per-bit drive enable for bus_rdata |

## Verification
A wrong bit count in the collector is not visible at once. It shows up on the fifth write after the error, when a register takes a shifted value or lands one write early or late. Because the collector is hidden, the bench keeps its own count and compares every register after every cycle. A bad register value shows up on the EEPROM pins, the SRAM enable or the readback enable in the same cycle it is stored. Chip select and data-in patterns are therefore checked right after each commit.

// File: rtl/sermap_pkg.sv
package sermap_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CHR0 = 2'd1,
    SEL_CHR1 = 2'd2,
    SEL_PRG  = 2'd3
  } reg_sel_e;

  localparam int NUM_REGS     = 4;
  localparam int CS_PATTERN   = 1;  // control bits 1:0 that raise chip select
  localparam int CTRL_SMALLCHR = 4; // control bit enabling EEPROM data-in
  localparam int CHR_DI_BIT   = 0;
  localparam int CHR_CLK_BIT  = 1;
  localparam int CHR_SRAM_OFF = 4;
  localparam int PRG_DO_OFF   = 4;
endpackage

// File: rtl/sermap_loader.sv
module sermap_loader #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_clear,
  input  logic             wr_bit,
  output logic             commit,
  output logic [REG_W-1:0] commit_val
);
  localparam int CNT_W = $clog2(REG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-2:0] sr_q;

  assign commit     = wr_en && !wr_clear && (cnt_q == LAST);
  assign commit_val = {wr_bit, sr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (wr_en) begin
      if (wr_clear || commit) begin
        cnt_q <= '0;
        sr_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sr_q  <= {wr_bit, sr_q[REG_W-2:1]};
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_clear) |=> (cnt_q == '0)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/sermap_regfile.sv
module sermap_regfile #(
  parameter int REG_W = 5,
  parameter int NREG  = 4,
  parameter logic [REG_W-1:0] CTRL_RST = 5'h0C
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          commit,
  input  logic [$clog2(NREG)-1:0]       commit_sel,
  input  logic [REG_W-1:0]              commit_val,
  output logic [NREG-1:0][REG_W-1:0]    regs_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [REG_W-1:0] RV = (g == 0) ? CTRL_RST : '0;
    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= RV;
      else if (commit && (commit_sel == g)) regs_q[g] <= commit_val;
    end
  end

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(regs_q)); // R3
endmodule

// File: rtl/sermap_eebridge.sv
module sermap_eebridge
  import sermap_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  ctrl,
  input  logic [REG_W-1:0]  chr0,
  input  logic [REG_W-1:0]  prg,
  input  logic              bus_cycle,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              ee_do,
  output logic              ee_cs,
  output logic              ee_di,
  output logic              ee_clk,
  output logic              sram_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_oe
);
  logic in_window;
  assign in_window = (cpu_addr[ADDR_W-1 -: 3] == 3'b011);

  assign ee_cs   = (ctrl[1:0] == 2'(CS_PATTERN));
  assign ee_di   = ctrl[CTRL_SMALLCHR] & chr0[CHR_DI_BIT];
  assign ee_clk  = chr0[CHR_CLK_BIT];
  assign sram_en = ~chr0[CHR_SRAM_OFF];

  always_comb begin
    bus_rdata = '0;
    bus_oe    = '0;
    if (bus_cycle && cpu_rw && in_window && !prg[PRG_DO_OFF]) begin
      bus_rdata[0] = ee_do;
      bus_oe[0]    = 1'b1;
    end
  end

  AST_DRIVE_ONLY_D0: assert property (@(posedge clk) disable iff (rst)
    $countones(bus_oe[DATA_W-1:1]) == 0); // R10
  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    bus_oe[0] |-> (cpu_rw && bus_cycle)); // R10
  AST_DRIVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    bus_oe[0] |-> (bus_rdata[0] == ee_do)); // R9
endmodule

// File: rtl/sermap_eeprom_top.sv
module sermap_eeprom_top
  import sermap_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [REG_W-1:0] CTRL_RST = 5'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cycle,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              ee_do,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  chr0_q,
  output logic [REG_W-1:0]  chr1_q,
  output logic [REG_W-1:0]  prg_q,
  output logic              ee_cs,
  output logic              ee_di,
  output logic              ee_clk,
  output logic              sram_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_oe
);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic                             wr_en;
  logic                             commit;
  logic [REG_W-1:0]                 commit_val;
  logic [NUM_REGS-1:0][REG_W-1:0]   regs;

  assign wr_en = bus_cycle && !cpu_rw && cpu_addr[ADDR_W-1];

  sermap_loader #(.REG_W(REG_W)) loader_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en),
    .wr_clear(cpu_wdata[DATA_W-1]),
    .wr_bit(cpu_wdata[0]),
    .commit(commit),
    .commit_val(commit_val)
  );

  sermap_regfile #(.REG_W(REG_W), .NREG(NUM_REGS), .CTRL_RST(CTRL_RST)) regs_i (
    .clk(clk), .rst(rst),
    .commit(commit),
    .commit_sel(cpu_addr[ADDR_W-2 -: SEL_W]),
    .commit_val(commit_val),
    .regs_q(regs)
  );

  assign ctrl_q = regs[SEL_CTRL];
  assign chr0_q = regs[SEL_CHR0];
  assign chr1_q = regs[SEL_CHR1];
  assign prg_q  = regs[SEL_PRG];

  sermap_eebridge #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) bridge_i (
    .clk(clk), .rst(rst),
    .ctrl(ctrl_q), .chr0(chr0_q), .prg(prg_q),
    .bus_cycle(bus_cycle), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
    .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_di(ee_di), .ee_clk(ee_clk), .sram_en(sram_en),
    .bus_rdata(bus_rdata), .bus_oe(bus_oe)
  );

  AST_NO_WRITE_BELOW: assert property (@(posedge clk) disable iff (rst)
    (bus_cycle && !cpu_rw && !cpu_addr[ADDR_W-1]) |=>
      ($stable(ctrl_q) && $stable(chr0_q) && $stable(chr1_q) && $stable(prg_q))); // R3
endmodule

// File: tb/sermap_eeprom_top_tb_top.sv
module sermap_eeprom_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cycle = 1'b0;
  logic        cpu_rw = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        ee_do = 1'b0;
  logic [4:0]  ctrl_q, chr0_q, chr1_q, prg_q;
  logic        ee_cs, ee_di, ee_clk, sram_en;
  logic [7:0]  bus_rdata, bus_oe;

  int vectors = 0;
  int fails = 0;

  // behavioural reference state
  int         m_count;
  logic [4:0] m_acc;
  logic [4:0] m_reg [4];

  always #10 clk = ~clk;

  sermap_eeprom_top dut_i (
    .clk(clk), .rst(rst), .bus_cycle(bus_cycle), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ee_do(ee_do),
    .ctrl_q(ctrl_q), .chr0_q(chr0_q), .chr1_q(chr1_q), .prg_q(prg_q),
    .ee_cs(ee_cs), .ee_di(ee_di), .ee_clk(ee_clk), .sram_en(sram_en),
    .bus_rdata(bus_rdata), .bus_oe(bus_oe)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_count = 0;
    m_acc = '0;
    m_reg[0] = 5'h0C;
    m_reg[1] = '0;
    m_reg[2] = '0;
    m_reg[3] = '0;
  endtask

  task automatic model_step();
    if (bus_cycle && !cpu_rw && cpu_addr >= 16'h8000) begin
      if (cpu_wdata[7]) begin
        m_count = 0;
        m_acc = '0;
      end else begin
        m_acc = m_acc | (5'(cpu_wdata[0]) << m_count);
        m_count = m_count + 1;
        if (m_count == 5) begin
          m_reg[cpu_addr[14:13]] = m_acc;
          m_count = 0;
          m_acc = '0;
        end
      end
    end
  endtask

  task automatic compare_all(string rtag);
    logic exp_oe;
    exp_oe = bus_cycle && cpu_rw && cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF
             && !m_reg[3][4];
    check({rtag, " ctrl"}, ctrl_q, m_reg[0]);
    check({rtag, " chr0"}, chr0_q, m_reg[1]);
    check({rtag, " chr1"}, chr1_q, m_reg[2]);
    check({rtag, " prg"},  prg_q,  m_reg[3]);
    check("R5 cs",  ee_cs,  (m_reg[0][1:0] == 2'b01));
    check("R6 di",  ee_di,  m_reg[0][4] ? m_reg[1][0] : 1'b0);
    check("R7 clk", ee_clk, m_reg[1][1]);
    check("R8 sram", sram_en, !m_reg[1][4]);
    check(exp_oe ? "R9 oe" : "R10 oe", bus_oe, {7'b0, exp_oe});
    if (exp_oe) check("R9 d0", bus_rdata[0], ee_do);
  endtask

  task automatic access(input logic [15:0] a, input logic [7:0] d, input logic rd,
                        input string rtag);
    @(negedge clk);
    bus_cycle = 1'b1;
    cpu_rw = rd;
    cpu_addr = a;
    cpu_wdata = d;
    #2;
    compare_all(rtag);
    @(posedge clk);
    #1;
    model_step();
  endtask

  task automatic idle(input string rtag);
    @(negedge clk);
    bus_cycle = 1'b0;
    cpu_rw = 1'b1;
    #2;
    compare_all(rtag);
  endtask

  task automatic load(input int sel, input logic [4:0] v, input string rtag);
    for (int i = 0; i < 5; i++)
      access(16'h8000 | 16'(sel << 13) | 16'h0123, {7'b0, v[i]}, 1'b0, rtag);
    idle(rtag);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] lcg;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle("R4 reset");
    idle("R4 reset");

    // control: chip select pattern 01, small banks on
    load(0, 5'h11, "R2");
    check("R5 cs high", ee_cs, 1);
    load(1, 5'h01, "R2"); check("R6 di follows", ee_di, 1);
    load(1, 5'h02, "R2"); check("R7 clk", ee_clk, 1);
    load(1, 5'h13, "R2"); check("R8 sram off", sram_en, 0);
    load(2, 5'h0A, "R2");

    // readback in window, ee_do both levels
    ee_do = 1'b1; access(16'h6000, 8'h00, 1'b1, "R9");
    ee_do = 1'b0; access(16'h7FFF, 8'h00, 1'b1, "R9");
    ee_do = 1'b1; access(16'h7ABC, 8'h00, 1'b1, "R9");
    access(16'h5FFF, 8'h00, 1'b1, "R10");
    access(16'h8000, 8'h00, 1'b1, "R10");
    access(16'h6000, 8'h00, 1'b0, "R10");
    idle("R3");

    // control bit 4 clear: data-in forced low
    load(0, 5'h01, "R2");
    check("R6 di gated", ee_di, 0);
    load(0, 5'h03, "R2");
    check("R5 cs low 11", ee_cs, 0);

    // interrupted sequence
    access(16'hC000, 8'h01, 1'b0, "R1");
    access(16'hC000, 8'h01, 1'b0, "R1");
    access(16'hC000, 8'h80, 1'b0, "R1");
    check("R1 prg unchanged", prg_q, 0);
    load(3, 5'h05, "R1");
    check("R1 prg fresh", prg_q, 5'h05);

    // writes below $8000 and reads above do not count
    access(16'hE000, 8'h00, 1'b0, "R3");
    access(16'h6000, 8'h01, 1'b0, "R3");
    access(16'h4020, 8'h01, 1'b0, "R3");
    access(16'hE000, 8'h01, 1'b1, "R3");
    idle("R3");
    for (int i = 0; i < 4; i++) access(16'hE000, 8'h01, 1'b0, "R3");
    idle("R3");
    check("R3 prg five bits", prg_q, 5'h1E);

    // program bank bit 4 set blocks readback
    ee_do = 1'b1;
    access(16'h6800, 8'h00, 1'b1, "R10");

    // pseudo-random traffic
    lcg = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 16'd25173 + 16'd13849;
      ee_do = lcg[3];
      if (lcg[15:14] == 2'b00)
        access({3'b011, lcg[12:0]}, 8'h00, 1'b1, "R9");
      else if (lcg[2:0] == 3'd0)
        access({1'b1, lcg[13:0], 1'b0}, {lcg[11], 6'b0, lcg[5]}, 1'b0, "R1");
      else
        access({1'b1, lcg[9:8], 13'h0}, {1'b0, 6'b0, lcg[5]}, lcg[7] & lcg[6], "R2");
    end
    idle("R2");

    // synchronous reset mid-operation
    access(16'h8000, 8'h01, 1'b0, "R4");
    @(negedge clk);
    rst = 1'b1;
    bus_cycle = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    idle("R4");
    check("R4 ctrl", ctrl_q, 5'h0C);
    load(2, 5'h1F, "R4");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule